// File: doc/BRIEF.md
# Pinning Register Rename Map

This block turns architectural destination register numbers into physical register numbers. A fresh physical register comes from an external free list for each write. A rename request can also carry a pin count. While the physical register that a table entry names still has pinned writes left, later writes to that architectural register get the same physical register back and nothing is popped. A micro-coded operation whose micro-operations each fill a different slice of one destination can therefore write back in parallel, with no read-modify-write chain between them.

The block accepts one request per cycle under a valid/ready handshake. In the accept cycle it pops the free list when an allocation is needed and clears the scoreboard ready bit of the physical register it hands out. One cycle later it returns a response that holds the new and the previous physical mapping, whether the request allocated, the writes-to-complete count, and an error flag. The architectural zero register is never renamed.

Top module: `rename_pin_map`

## Requirements
- R1: After reset, architectural register i maps to physical register i, and every pinned-write counter is zero.
- R2: A request to architectural register 0 returns the current mapping of register 0 as both new and previous mapping, pops nothing, and is accepted even when the free list is empty.
- R3: When the current mapping has a pinned-write count of zero, an accepted request to a nonzero register asserts fl_pop in the accept cycle, takes fl_phys as the new mapping, writes it into the table, and reports the replaced mapping as rsp_prev_phys with rsp_fresh=1.
- R4: When the current mapping has a nonzero pinned-write count, the request returns that same physical register with rsp_fresh=0, pops nothing, leaves the table unchanged and decrements the count by one. When the count reaches zero, the next write allocates again.
- R5: A request with a nonzero pin count that hits a mapping which is still pinned sets rsp_err=1 and is otherwise handled as in R4. rsp_err is 0 in every other case.
- R6: On an allocation, the new register's pinned-write count becomes req_pin and rsp_wtc is req_pin+1. rsp_wtc is 0 on a reuse or a zero-register request.
- R7: In every accept cycle, sb_clr_valid is 1 and sb_clr_phys equals the physical register that the response will carry. sb_clr_valid is 0 in all other cycles.
- R8: req_ready is 0 exactly when the request needs an allocation and fl_valid is 0. A reuse or zero-register request stays ready while the free list is empty.
- R9: rsp_valid is 1 in the cycle after each accept and 0 otherwise, including after reset.
- R10: The pin count of a request to register 0 is ignored: it causes neither an error nor any pinning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Rename request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_arch | input | ARCH_W | Architectural destination register |
| req_pin | input | PIN_W | Number of further writes to pin to the new mapping |
| fl_valid | input | 1 | Free list holds an entry |
| fl_phys | input | PHYS_W | Physical register at the head of the free list |
| fl_pop | output | 1 | Pop the free-list head this cycle |
| sb_clr_valid | output | 1 | Clear a scoreboard ready bit |
| sb_clr_phys | output | PHYS_W | Physical register whose ready bit is cleared |
| rsp_valid | output | 1 | Response valid |
| rsp_phys | output | PHYS_W | Physical register granted |
| rsp_prev_phys | output | PHYS_W | Mapping held before the request |
| rsp_fresh | output | 1 | Request allocated a new physical register |
| rsp_err | output | 1 | Request tried to pin a mapping that is already pinned |
| rsp_wtc | output | PIN_W+1 | Writes-to-complete count on allocation |

## Verification
The bench builds the block with 8 architectural and 12 physical registers and a 3-bit pin count. This leaves only four spare registers, so allocation, recycling of a replaced mapping and reuse of the same physical numbers all occur within a short run. Pin counts of up to 7 let a pinned mapping span several reuses, and some requests carry a pin count while their mapping is still pinned, which drives the error path. The free list is withheld on random cycles so that stalls meet both allocating and reusing requests.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    RPM_ZERO  = 2'd0,
    RPM_REUSE = 2'd1,
    RPM_ALLOC = 2'd2
  } rpm_act_e;
endpackage

// File: rtl/rpm_map_table.sv
module rpm_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int ARCH_W   = 3,
  parameter int PHYS_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ARCH_W-1:0] rd_arch,
  output logic [PHYS_W-1:0] rd_phys,
  input  logic              wr_en,
  input  logic [ARCH_W-1:0] wr_arch,
  input  logic [PHYS_W-1:0] wr_phys
);
  logic [PHYS_W-1:0] ent [NUM_ARCH];

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
    logic              ent_en;
    logic [PHYS_W-1:0] ent_q;

    assign ent_en = wr_en && (wr_arch == ARCH_W'(a));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= PHYS_W'(a);
      else if (ent_en) ent_q <= wr_phys;
    end

    assign ent[a] = ent_q;
  end

  always_comb begin
    rd_phys = '0;
    if (int'(rd_arch) < NUM_ARCH) rd_phys = ent[rd_arch];
  end
endmodule

// File: rtl/rpm_pin_ctr.sv
module rpm_pin_ctr #(
  parameter int NUM_PHYS = 16,
  parameter int PHYS_W   = 4,
  parameter int PIN_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHYS_W-1:0] rd_phys,
  output logic [PIN_W-1:0]  rd_cnt,
  input  logic              set_en,
  input  logic [PHYS_W-1:0] set_phys,
  input  logic [PIN_W-1:0]  set_val,
  input  logic              dec_en,
  input  logic [PHYS_W-1:0] dec_phys
);
  logic [PIN_W-1:0] cnt [NUM_PHYS];

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_cnt
    logic [PIN_W-1:0] cnt_d, cnt_q;
    logic             hit_set, hit_dec;

    assign hit_set = set_en && (set_phys == PHYS_W'(p));
    assign hit_dec = dec_en && (dec_phys == PHYS_W'(p)) && (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (hit_set)      cnt_d = set_val;
      else if (hit_dec) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign cnt[p] = cnt_q;
  end

  always_comb begin
    rd_cnt = '0;
    if (int'(rd_phys) < NUM_PHYS) rd_cnt = cnt[rd_phys];
  end
endmodule

// File: rtl/rpm_ctrl.sv
module rpm_ctrl
  import rpm_pkg::*;
#(
  parameter int ARCH_W    = 3,
  parameter int PHYS_W    = 4,
  parameter int PIN_W     = 3,
  parameter int ZERO_ARCH = 0
) (
  input  logic              req_valid,
  input  logic [ARCH_W-1:0] req_arch,
  input  logic [PIN_W-1:0]  req_pin,
  input  logic [PHYS_W-1:0] cur_phys,
  input  logic [PIN_W-1:0]  cur_cnt,
  input  logic              fl_valid,
  input  logic [PHYS_W-1:0] fl_phys,
  output logic              req_ready,
  output logic              fire,
  output logic              alloc,
  output logic              dec_en,
  output logic [PHYS_W-1:0] new_phys,
  output logic              err,
  output logic [PIN_W:0]    wtc
);
  rpm_act_e act;

  always_comb begin
    if (req_arch == ARCH_W'(ZERO_ARCH)) act = RPM_ZERO;
    else if (cur_cnt != '0)             act = RPM_REUSE;
    else                                act = RPM_ALLOC;
  end

  assign req_ready = (act != RPM_ALLOC) || fl_valid;
  assign fire      = req_valid && req_ready;
  assign alloc     = fire && (act == RPM_ALLOC);
  assign dec_en    = fire && (act == RPM_REUSE);
  assign new_phys  = (act == RPM_ALLOC) ? fl_phys : cur_phys;
  assign err       = (act == RPM_REUSE) && (req_pin != '0);
  assign wtc       = (act == RPM_ALLOC) ? ({1'b0, req_pin} + 1'b1) : '0;
endmodule

// File: rtl/rename_pin_map.sv
module rename_pin_map #(
  parameter int NUM_ARCH  = 8,
  parameter int NUM_PHYS  = 16,
  parameter int PIN_W     = 3,
  parameter int ZERO_ARCH = 0,
  localparam int ARCH_W   = $clog2(NUM_ARCH),
  localparam int PHYS_W   = $clog2(NUM_PHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ARCH_W-1:0] req_arch,
  input  logic [PIN_W-1:0]  req_pin,
  input  logic              fl_valid,
  input  logic [PHYS_W-1:0] fl_phys,
  output logic              fl_pop,
  output logic              sb_clr_valid,
  output logic [PHYS_W-1:0] sb_clr_phys,
  output logic              rsp_valid,
  output logic [PHYS_W-1:0] rsp_phys,
  output logic [PHYS_W-1:0] rsp_prev_phys,
  output logic              rsp_fresh,
  output logic              rsp_err,
  output logic [PIN_W:0]    rsp_wtc
);
  logic [PHYS_W-1:0] cur_phys, new_phys;
  logic [PIN_W-1:0]  cur_cnt;
  logic              fire, alloc, dec_en, err;
  logic [PIN_W:0]    wtc;

  rpm_map_table #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .ARCH_W(ARCH_W), .PHYS_W(PHYS_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_arch(req_arch), .rd_phys(cur_phys),
    .wr_en(alloc), .wr_arch(req_arch), .wr_phys(fl_phys)
  );

  rpm_pin_ctr #(
    .NUM_PHYS(NUM_PHYS), .PHYS_W(PHYS_W), .PIN_W(PIN_W)
  ) u_pin (
    .clk(clk), .rst_n(rst_n),
    .rd_phys(cur_phys), .rd_cnt(cur_cnt),
    .set_en(alloc), .set_phys(fl_phys), .set_val(req_pin),
    .dec_en(dec_en), .dec_phys(cur_phys)
  );

  rpm_ctrl #(
    .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .PIN_W(PIN_W), .ZERO_ARCH(ZERO_ARCH)
  ) u_ctrl (
    .req_valid(req_valid), .req_arch(req_arch), .req_pin(req_pin),
    .cur_phys(cur_phys), .cur_cnt(cur_cnt),
    .fl_valid(fl_valid), .fl_phys(fl_phys),
    .req_ready(req_ready), .fire(fire), .alloc(alloc), .dec_en(dec_en),
    .new_phys(new_phys), .err(err), .wtc(wtc)
  );

  assign fl_pop       = alloc;
  assign sb_clr_valid = fire;
  assign sb_clr_phys  = new_phys;

  // response: valid has reset, payload is enable-loaded
  logic rsp_valid_d;
  assign rsp_valid_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_d;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      rsp_phys      <= new_phys;
      rsp_prev_phys <= cur_phys;
      rsp_fresh     <= alloc;
      rsp_err       <= err;
      rsp_wtc       <= wtc;
    end
  end
endmodule

// File: rtl/rename_pin_map_chk.sv
module rename_pin_map_chk #(
  parameter int ARCH_W    = 3,
  parameter int PHYS_W    = 4,
  parameter int PIN_W     = 3,
  parameter int ZERO_ARCH = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ARCH_W-1:0] req_arch,
  input logic [PIN_W-1:0]  req_pin,
  input logic              fl_valid,
  input logic [PHYS_W-1:0] fl_phys,
  input logic              fl_pop,
  input logic              sb_clr_valid,
  input logic [PHYS_W-1:0] sb_clr_phys,
  input logic              rsp_valid,
  input logic [PHYS_W-1:0] rsp_phys,
  input logic [PHYS_W-1:0] rsp_prev_phys,
  input logic              rsp_fresh,
  input logic              rsp_err,
  input logic [PIN_W:0]    rsp_wtc
);
  AST_POP_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |-> (fl_valid && req_valid && req_ready)); // R3
  AST_POP_GIVES_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |=> (rsp_phys == $past(fl_phys) && rsp_fresh)); // R3
  AST_ZERO_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_arch == ARCH_W'(ZERO_ARCH)) |-> (!fl_pop && req_ready)); // R2
  AST_ERR_NOT_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (!rsp_fresh && rsp_phys == rsp_prev_phys)); // R5
  AST_WTC_ONLY_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fresh) |-> (rsp_wtc == '0)); // R6
  AST_SB_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    sb_clr_valid |-> (req_valid && req_ready)); // R7
  AST_SB_MATCHES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    sb_clr_valid |=> (rsp_phys == $past(sb_clr_phys))); // R7
  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid); // R9
  AST_STALL_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !fl_valid); // R8
endmodule

bind rename_pin_map rename_pin_map_chk #(
  .ARCH_W(ARCH_W), .PHYS_W(PHYS_W), .PIN_W(PIN_W), .ZERO_ARCH(ZERO_ARCH)
) u_chk (.*);

// File: tb/rename_pin_map_tb.sv
`timescale 1ns/1ps
module rename_pin_map_tb;
  localparam int NA = 8;
  localparam int NP = 12;
  localparam int PW = 3;
  localparam int AW = $clog2(NA);
  localparam int PHW = $clog2(NP);

  logic clk, rst_n;
  logic req_valid, req_ready;
  logic [AW-1:0] req_arch;
  logic [PW-1:0] req_pin;
  logic fl_valid, fl_pop, sb_clr_valid, rsp_valid, rsp_fresh, rsp_err;
  logic [PHW-1:0] fl_phys, sb_clr_phys, rsp_phys, rsp_prev_phys;
  logic [PW:0] rsp_wtc;

  rename_pin_map #(.NUM_ARCH(NA), .NUM_PHYS(NP), .PIN_W(PW), .ZERO_ARCH(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_arch(req_arch), .req_pin(req_pin), .fl_valid(fl_valid), .fl_phys(fl_phys),
    .fl_pop(fl_pop), .sb_clr_valid(sb_clr_valid), .sb_clr_phys(sb_clr_phys),
    .rsp_valid(rsp_valid), .rsp_phys(rsp_phys), .rsp_prev_phys(rsp_prev_phys),
    .rsp_fresh(rsp_fresh), .rsp_err(rsp_err), .rsp_wtc(rsp_wtc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_map [NA];
  int m_pin [NP];
  int fq [$];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit needs_alloc(int a);
    return (a != 0) && (m_pin[m_map[a]] == 0);
  endfunction

  function automatic bit exp_ready(int a, bit have);
    return !needs_alloc(a) || have;
  endfunction

  task automatic step(bit v, int a, int p, bit fen);
    bit have, er, fire, alloc;
    int e_phys, e_prev, e_err, e_wtc;
    @(negedge clk);
    have = fen && (fq.size() > 0);
    fl_valid = have;
    fl_phys = have ? PHW'(fq[0]) : '0;
    req_valid = v;
    req_arch = AW'(a);
    req_pin = PW'(p);
    #1;
    er = exp_ready(a, have);
    chk("R8 req_ready", int'(req_ready), int'(er));
    fire = v && er;
    alloc = fire && needs_alloc(a);
    chk("R3 fl_pop", int'(fl_pop), int'(alloc));
    chk("R7 sb_clr_valid", int'(sb_clr_valid), int'(fire));
    e_prev = m_map[a];
    e_err = 0;
    e_wtc = 0;
    e_phys = e_prev;
    if (fire) begin
      if (a == 0) begin
        e_phys = m_map[0];
      end else if (alloc) begin
        e_phys = fq.pop_front();
        fq.push_back(e_prev);
        m_map[a] = e_phys;
        m_pin[e_phys] = p;
        e_wtc = p + 1;
      end else begin
        e_err = (p != 0) ? 1 : 0;
        m_pin[e_phys] = m_pin[e_phys] - 1;
      end
      chk("R7 sb_clr_phys", int'(sb_clr_phys), e_phys);
    end
    @(posedge clk);
    #1;
    chk("R9 rsp_valid", int'(rsp_valid), int'(fire));
    if (fire) begin
      chk(a == 0 ? "R2 rsp_phys" : (alloc ? "R3 rsp_phys" : "R4 rsp_phys"), int'(rsp_phys), e_phys);
      chk("R1/R3 rsp_prev_phys", int'(rsp_prev_phys), e_prev);
      chk("R4 rsp_fresh", int'(rsp_fresh), int'(alloc));
      chk(a == 0 ? "R10 rsp_err" : "R5 rsp_err", int'(rsp_err), e_err);
      chk("R6 rsp_wtc", int'(rsp_wtc), e_wtc);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_arch = '0; req_pin = '0;
    fl_valid = 1'b0; fl_phys = '0;
    for (int i = 0; i < NA; i++) m_map[i] = i;
    for (int i = 0; i < NP; i++) m_pin[i] = 0;
    for (int i = NA; i < NP; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 rsp_valid after reset", int'(rsp_valid), 0);
    chk("R7 sb_clr_valid after reset", int'(sb_clr_valid), 0);

    step(1, 3, 0, 1);   // R1 R3 fresh allocation, prev is identity
    step(1, 0, 5, 0);   // R2 R10 zero register, empty free list, pin ignored
    step(1, 0, 0, 1);   // R10 zero reg still unpinned
    step(1, 5, 2, 1);   // R6 wtc 3
    step(1, 5, 0, 1);   // R4 reuse
    step(1, 5, 0, 0);   // R4 R8 reuse while free list empty
    step(1, 5, 0, 1);   // R4 pin exhausted, allocates again
    step(1, 2, 2, 1);
    step(1, 2, 1, 1);   // R5 pin while pinned
    step(1, 2, 0, 1);   // R4
    step(1, 2, 0, 1);   // R3 allocates
    step(1, 4, 0, 0);   // R8 stall
    step(0, 4, 0, 1);   // R9 idle
    step(1, 4, 7, 1);   // R6 max pin
    for (int k = 0; k < 7; k++) step(1, 4, 0, 0); // R4 long reuse run
    step(1, 4, 0, 1);
    for (int k = 0; k < 600; k++) begin
      step($urandom_range(0, 3) != 0, $urandom_range(0, NA - 1),
           ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0,
           $urandom_range(0, 4) != 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule